// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter with Settling Flag

This block turns the one-bit stream of a sigma-delta modulator into a 12-bit two's-complement word. It uses a third-order cascaded integrator-comb decimator. The modulator clock runs at the output word rate times the decimation ratio, so with a 125 Hz word rate a new conversion arrives every 8 ms. Three integrators run at the modulator rate. A decimation tick then samples the last integrator, and three comb stages produce one full-precision result per conversion. That result is clipped, re-centred and cut down to the output width.

Every conversion is written to the data output, and each one is marked by a single-cycle strobe. Raw data alone does not say whether the filter memory still holds samples from before a reset or an input step. For that, a separate settled flag rises only when the whole impulse-response window holds clean samples. After a reset this takes three conversions. A step hint tells the block that the analog input has jumped. A hint at a conversion boundary restarts the three-conversion wait. A hint at any other moment adds one more conversion to the wait.

Top module: `sinc3_decimator`

## Requirements
- R1: While `rst` is high at a clock edge, all integrator and comb state is cleared, and after that edge `conv_data` is 0, `conv_strobe` is 0 and `conv_settled` is 0.
- R2: `conv_strobe` is high for exactly one clock in every DEC_RATIO clocks (16 by default), and never for two clocks in a row.
- R3: `conv_data` is overwritten in the cycle `conv_strobe` is high, including conversions made while `conv_settled` is low, and it holds its value in every other cycle.
- R4: After reset, `conv_settled` is low on the first and second strobes, and it rises in the same cycle as the third strobe.
- R5: Once settled, a constant input of all ones gives +2047, clipped from the one value above the range, and all zeros gives -2048.
- R6: Once settled, an input with a ones density d (period dividing DEC_RATIO) gives exactly d*4096-2048: density 1/2 gives 0, 1/4 gives -1024 and 3/4 gives +1024.
- R7: A `step_hint` seen in the cycle that ends a conversion clears `conv_settled` on that conversion's strobe. The flag returns on the third strobe after it.
- R8: A `step_hint` seen in any other cycle clears `conv_settled` in the next cycle. The flag returns on the fourth strobe after the hint.
- R9: Once `conv_settled` is high, it stays high across every later strobe until a reset or a step hint.
- R10: The integrators wrap modulo 2^(3*log2(DEC_RATIO)+1), and the comb result still never exceeds DEC_RATIO^3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, DEC_RATIO times the word rate |
| rst | input | 1 | Synchronous filter reset, active high |
| mod_bit | input | 1 | Modulator output bit (1 = positive full scale) |
| step_hint | input | 1 | Marks that the analog input just changed abruptly |
| conv_data | output | OUT_W | Latest conversion, two's complement |
| conv_strobe | output | 1 | One-clock pulse when a new conversion is written |
| conv_settled | output | 1 | Current conversion comes from a fully settled filter |

## Verification
Some behaviours are checked by the assertions in every cycle: the strobe is one clock wide, the data holds between strobes, settled rises only together with a strobe, a hint drops settled, settled stays high until a reset or hint, and the comb result stays within range in spite of wrapping integrators. Other behaviours only the bench scenarios can show. These are the numeric values for each input density, how many strobes pass before settled returns after a reset or after an aligned or unaligned hint, the spacing between strobes, and the fact that unsettled conversions still change the data.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

   // accumulator width for an order-N CIC with power-of-two ratio and 1-bit input
   function automatic int cic_acc_width(input int order, input int ratio);
      return order * $clog2(ratio) + 1;
   endfunction

   function automatic bit is_pow2(input int value);
      return (value > 0) && ((value & (value - 1)) == 0);
   endfunction

   typedef enum logic [1:0] {
      HINT_NONE    = 2'd0,
      HINT_ALIGNED = 2'd1,
      HINT_MIDWAY  = 2'd2
   } step_kind_e;

endpackage

// File: rtl/sinc3_integrator_chain.sv
module sinc3_integrator_chain #(
   parameter int ORDER = 3,
   parameter int ACC_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_bit,
   output logic [ACC_W-1:0] acc_out
);

   logic [ACC_W-1:0] ext_in;
   assign ext_in = {{(ACC_W-1){1'b0}}, in_bit};

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      logic [ACC_W-1:0] feed;
      logic [ACC_W-1:0] acc_q;
      if (k == 0) begin : g_head
         assign feed = ext_in;
      end else begin : g_tail
         assign feed = g_stage[k-1].acc_q;
      end
      // wrap-around add: overflow cancels later in the comb differences
      always_ff @(posedge clk) begin
         if (rst) acc_q <= '0;
         else     acc_q <= acc_q + feed;
      end
   end

   assign acc_out = g_stage[ORDER-1].acc_q;

   p_integ_clear_r1: assert property (@(posedge clk) rst |=> (acc_out == '0))
      else $error("integrator not cleared by reset");

endmodule

// File: rtl/sinc3_comb_chain.sv
module sinc3_comb_chain #(
   parameter int ORDER = 3,
   parameter int ACC_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample_en,
   input  logic [ACC_W-1:0] din,
   output logic [ACC_W-1:0] dout
);

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      logic [ACC_W-1:0] feed;
      logic [ACC_W-1:0] dly_q;
      logic [ACC_W-1:0] diff;
      if (k == 0) begin : g_head
         assign feed = din;
      end else begin : g_tail
         assign feed = g_stage[k-1].diff;
      end
      assign diff = feed - dly_q;
      always_ff @(posedge clk) begin
         if (rst)            dly_q <= '0;
         else if (sample_en) dly_q <= feed;
      end
   end

   assign dout = g_stage[ORDER-1].diff;

   // R10: result bounded by ratio^order = 2^(ACC_W-1) despite integrator wrap
   p_comb_range_r10: assert property (@(posedge clk) disable iff (rst)
      (sample_en && dout[ACC_W-1]) |-> (dout[ACC_W-2:0] == '0))
      else $error("comb result out of range");

endmodule

// File: rtl/sinc3_quantize.sv
module sinc3_quantize #(
   parameter int ACC_W = 13,
   parameter int OUT_W = 12
) (
   input  logic [ACC_W-1:0]        full_in,
   output logic signed [OUT_W-1:0] word_out
);

   localparam int MAG_W  = ACC_W - 1;
   localparam int DROP_W = MAG_W - OUT_W;

   logic [MAG_W-1:0] clipped;
   logic [MAG_W-1:0] centred;

   // only the exact full-scale value sets the top bit; clip it one code down
   assign clipped = full_in[MAG_W] ? {MAG_W{1'b1}} : full_in[MAG_W-1:0];
   // offset binary to two's complement: invert the top bit
   assign centred = {~clipped[MAG_W-1], clipped[MAG_W-2:0]};

   if (DROP_W == 0) begin : g_exact
      assign word_out = centred;
   end else begin : g_trunc
      assign word_out = centred[MAG_W-1 -: OUT_W];
   end

endmodule

// File: rtl/sinc3_settle_tracker.sv
module sinc3_settle_tracker #(
   parameter int SETTLE_CONV = 3,
   parameter int EXTRA_CONV  = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic step_hint,
   output logic settled
);
   import sinc3_pkg::*;

   localparam int MAX_WAIT = SETTLE_CONV + EXTRA_CONV;
   localparam int NEED_W   = $clog2(MAX_WAIT + 1);

   logic [NEED_W-1:0] need_q;
   step_kind_e        kind;

   always_comb begin
      if (!step_hint) kind = HINT_NONE;
      else if (tick)  kind = HINT_ALIGNED;
      else            kind = HINT_MIDWAY;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         need_q  <= NEED_W'(SETTLE_CONV);
         settled <= 1'b0;
      end else begin
         case (kind)
            HINT_ALIGNED: begin
               need_q  <= NEED_W'(SETTLE_CONV);
               settled <= 1'b0;
            end
            HINT_MIDWAY: begin
               need_q  <= NEED_W'(MAX_WAIT);
               settled <= 1'b0;
            end
            default: begin
               if (tick) begin
                  if (need_q != '0) need_q <= need_q - 1'b1;
                  settled <= (need_q <= NEED_W'(1));
               end
            end
         endcase
      end
   end

   p_hint_clears_r8: assert property (@(posedge clk) disable iff (rst)
      step_hint |=> !settled)
      else $error("settled survived a step hint");

   p_settled_holds_r9: assert property (@(posedge clk) disable iff (rst)
      (settled && !step_hint) |=> settled)
      else $error("settled dropped without reset or hint");

   p_wait_bound_r7: assert property (@(posedge clk) disable iff (rst)
      need_q <= NEED_W'(MAX_WAIT))
      else $error("settle counter beyond its limit");

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
   parameter int DEC_RATIO    = 16,
   parameter int OUT_W        = 12,
   parameter int FILTER_ORDER = 3,
   parameter int EXTRA_CONV   = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    mod_bit,
   input  logic                    step_hint,
   output logic signed [OUT_W-1:0] conv_data,
   output logic                    conv_strobe,
   output logic                    conv_settled
);
   import sinc3_pkg::*;

   localparam int LOG_R = $clog2(DEC_RATIO);
   localparam int ACC_W = cic_acc_width(FILTER_ORDER, DEC_RATIO);

   if (!is_pow2(DEC_RATIO) || DEC_RATIO < 4) begin : g_bad_ratio
      $error("DEC_RATIO must be a power of two of at least 4");
   end
   if (ACC_W - 1 < OUT_W) begin : g_bad_width
      $error("filter gain too small for OUT_W; raise DEC_RATIO");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("OUT_W must be at least 2");
   end

   logic [LOG_R-1:0]        phase_q;
   logic                    tick;
   logic [ACC_W-1:0]        integ_out;
   logic [ACC_W-1:0]        comb_out;
   logic signed [OUT_W-1:0] word;

   assign tick = (phase_q == LOG_R'(DEC_RATIO - 1));

   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_q + 1'b1;
   end

   sinc3_integrator_chain #(.ORDER(FILTER_ORDER), .ACC_W(ACC_W)) u_integ (
      .clk     (clk),
      .rst     (rst),
      .in_bit  (mod_bit),
      .acc_out (integ_out)
   );

   sinc3_comb_chain #(.ORDER(FILTER_ORDER), .ACC_W(ACC_W)) u_comb (
      .clk       (clk),
      .rst       (rst),
      .sample_en (tick),
      .din       (integ_out),
      .dout      (comb_out)
   );

   sinc3_quantize #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_quant (
      .full_in  (comb_out),
      .word_out (word)
   );

   sinc3_settle_tracker #(.SETTLE_CONV(FILTER_ORDER), .EXTRA_CONV(EXTRA_CONV)) u_settle (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .step_hint (step_hint),
      .settled   (conv_settled)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         conv_data   <= '0;
         conv_strobe <= 1'b0;
      end else begin
         conv_strobe <= tick;
         if (tick) conv_data <= word;
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!conv_strobe && !conv_settled && conv_data == '0))
      else $error("outputs not cleared by reset");

   p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
      conv_strobe |=> !conv_strobe)
      else $error("strobe wider than one clock");

   p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !conv_strobe |-> $stable(conv_data))
      else $error("data changed without strobe");

   p_settle_with_strobe_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(conv_settled) |-> conv_strobe)
      else $error("settled rose away from a strobe");

endmodule

// File: tb/sinc3_decimator_bench.sv
module sinc3_decimator_bench;

   localparam int R     = 16;
   localparam int OUT_W = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mod_bit = 1'b0;
   logic step_hint = 1'b0;
   logic signed [OUT_W-1:0] conv_data;
   logic conv_strobe;
   logic conv_settled;

   always #10 clk = ~clk;

   sinc3_decimator #(.DEC_RATIO(R), .OUT_W(OUT_W)) u_sinc3_decimator (
      .clk          (clk),
      .rst          (rst),
      .mod_bit      (mod_bit),
      .step_hint    (step_hint),
      .conv_data    (conv_data),
      .conv_strobe  (conv_strobe),
      .conv_settled (conv_settled)
   );

   typedef struct packed {
      logic chk;
      logic is_frac;
      int   val;
   } sb_item_t;

   sb_item_t sb_q[$];
   int checks = 0;
   int failures = 0;
   int strobe_cnt = 0;
   int cyc = 0;
   int prev_cyc = 0;
   int last_gap = 0;
   int last_data = 0;
   logic last_settled = 1'b0;
   logic [3:0] pat = 4'b0000;
   logic [1:0] bit_idx = 2'd0;
   bit done = 1'b0;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // stimulus: repeating 4-bit pattern, changed away from the rising edge
   always @(negedge clk) begin
      mod_bit = pat[bit_idx];
      bit_idx = bit_idx + 2'd1;
   end

   // monitor: records each conversion and scores it against the queue
   always @(negedge clk) begin
      cyc++;
      if (conv_strobe === 1'b1) begin
         last_gap     = cyc - prev_cyc;
         prev_cyc     = cyc;
         last_data    = int'(conv_data);
         last_settled = conv_settled;
         if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            if (it.chk) begin
               if (it.is_frac) check("R6 density value", last_data, it.val);
               else            check("R5 full-scale value", last_data, it.val);
               check("R9 settled stays high", int'(last_settled), 1);
            end
         end
         strobe_cnt++;
      end
   end

   task automatic wait_strobe();
      int c;
      c = strobe_cnt;
      wait (strobe_cnt != c);
   endtask

   // driver: queue expectations for n conversions, first four skipped
   task automatic run_pattern(input logic [3:0] p, input int n, input int expv, input bit frac);
      int c;
      pat = p;
      for (int i = 0; i < n; i++) sb_q.push_back('{chk: (i >= 4), is_frac: frac, val: expv});
      c = strobe_cnt;
      wait (strobe_cnt >= c + n);
   endtask

   task automatic apply_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 data zero in reset", int'(conv_data), 0);
      check("R1 strobe low in reset", int'(conv_strobe), 0);
      check("R1 settled low in reset", int'(conv_settled), 0);
      rst = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired before the scenarios ended");
      finish_run();
   end

   initial begin
      pat = 4'b1111;
      apply_reset();

      // R3 and R4: unsettled conversions still write data
      wait_strobe();
      check("R4 settled low on 1st strobe", int'(last_settled), 0);
      check("R3 data written while unsettled", int'(last_data != 0), 1);
      @(negedge clk);
      check("R2 strobe one cycle wide", int'(conv_strobe), 0);
      wait_strobe();
      check("R4 settled low on 2nd strobe", int'(last_settled), 0);
      wait_strobe();
      check("R4 settled high on 3rd strobe", int'(last_settled), 1);
      wait_strobe();
      check("R2 strobe spacing", last_gap, R);

      // R5, R6 (R10: integrators wrap many times during these runs)
      run_pattern(4'b1111, 8, 2047, 1'b0);
      run_pattern(4'b0000, 8, -2048, 1'b0);
      run_pattern(4'b1010, 8, 0, 1'b1);
      run_pattern(4'b0001, 8, -1024, 1'b1);
      run_pattern(4'b0111, 8, 1024, 1'b1);
      check("R2 strobe spacing steady", last_gap, R);

      // R7: hint in the conversion-ending cycle
      wait_strobe();
      repeat (R - 1) @(negedge clk);
      step_hint = 1'b1;
      begin
         int c;
         c = strobe_cnt;
         @(negedge clk);
         step_hint = 1'b0;
         wait (strobe_cnt != c);
      end
      check("R7 settled cleared on aligned strobe", int'(last_settled), 0);
      wait_strobe();
      check("R7 settled low 1 after aligned hint", int'(last_settled), 0);
      wait_strobe();
      check("R7 settled low 2 after aligned hint", int'(last_settled), 0);
      wait_strobe();
      check("R7 settled back on 3rd strobe", int'(last_settled), 1);

      // R8: hint in the middle of a conversion
      wait_strobe();
      repeat (5) @(negedge clk);
      step_hint = 1'b1;
      @(negedge clk);
      step_hint = 1'b0;
      check("R8 settled cleared after midway hint", int'(conv_settled), 0);
      for (int k = 1; k <= 3; k++) begin
         wait_strobe();
         check("R8 settled low before 4th strobe", int'(last_settled), 0);
      end
      wait_strobe();
      check("R8 settled back on 4th strobe", int'(last_settled), 1);
      wait_strobe();
      check("R9 settled kept on next strobe", int'(last_settled), 1);

      // R1 and R4 again: reset in the middle of a run
      pat = 4'b1111;
      repeat (7) @(negedge clk);
      apply_reset();
      wait_strobe();
      check("R4 settled low 1st strobe after rerun", int'(last_settled), 0);
      wait_strobe();
      check("R4 settled low 2nd strobe after rerun", int'(last_settled), 0);
      wait_strobe();
      check("R4 settled high 3rd strobe after rerun", int'(last_settled), 1);
      run_pattern(4'b1111, 6, 2047, 1'b0);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule